// File: doc/BRIEF.md
# Cascadable Tap Shift Register

This block is a bank of serial shift registers whose read point is chosen by an address rather than fixed at the end. It holds four physical segments of 32 one-bit stages each. On every rising clock edge with the shift enable high, each segment takes one new bit at its head, and every stored bit moves one stage deeper. The stage that each output shows is picked combinationally by an address. A delay line can therefore be fixed, with the address held constant, or elastic, with the address moved while data streams through.

A two-bit configuration input decides how the segments are strung together. The options are four separate 32-stage lines, two 64-stage lines, one 128-stage line, or a 96-stage line beside a separate 32-stage line. When segments are joined, the deepest stage of one segment feeds the head of the next. The address of the chain head widens to cover the longer line. Every segment also presents its deepest stage on a dedicated tail output. The stages have no reset and no parallel load. Changing the configuration only rewires the segment inputs and the output selection; the stored bits are kept.

Top module: `casc_srl_bank`

## Requirements
- R1: With `cfg_i` = 2'b00, segment k is an independent line fed by `ser_i[k]`. `tap_o[k]` shows stage `addr_i[k][4:0]` of segment k, where stage s holds the bit accepted on the (s+1)-th most recent enabled edge.
- R2: Address 0 shows the bit accepted on the most recent enabled clock edge.
- R3: While `shift_en_i` is low, clock edges change no stage, so every output holds for fixed inputs.
- R4: With `cfg_i` = 2'b01, segment 0 feeds segment 1 and segment 2 feeds segment 3. The heads are `ser_i[0]` and `ser_i[2]`, and `ser_i[1]` and `ser_i[3]` are ignored. `tap_o[0]` and `tap_o[2]` show chain stage `addr_i[j][5:0]`, and `tap_o[1]` and `tap_o[3]` are 0.
- R5: With `cfg_i` = 2'b10, all four segments form one 128-stage line fed by `ser_i[0]`. `tap_o[0]` shows chain stage `addr_i[0][6:0]`. `ser_i[3:1]` are ignored and `tap_o[3:1]` are 0.
- R6: With `cfg_i` = 2'b11, segments 0 to 2 form a 96-stage line fed by `ser_i[0]`, read through `addr_i[0][6:0]` on `tap_o[0]`. Addresses 96 to 127 read 0. Segment 3 is an independent line fed by `ser_i[3]` and read through `addr_i[3][4:0]` on `tap_o[3]`. `tap_o[1]` and `tap_o[2]` are 0.
- R7: `tail_o[k]` always shows stage 31 of segment k, in every configuration.
- R8: A change of address or configuration shows on `tap_o` in the same cycle, with no clock edge needed.
- R9: Address bits above the width a line needs are ignored: bits 6:5 for a 32-stage line, and bit 6 for a 64-stage line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; shifting happens on its rising edge |
| shift_en_i | input | 1 | Active-high shift enable |
| cfg_i | input | 2 | Segment chaining configuration |
| ser_i | input | 4 | Serial input at the head of each segment |
| addr_i | input | 4x7 | Tap address per line, index k for segment k |
| tap_o | output | 4 | Addressed stage of each line head |
| tail_o | output | 4 | Deepest stage of each segment |

## Verification
Address and configuration effects are due in the same cycle, with no register in the path. The shifted contents are due one rising edge after an enabled cycle. The bench changes every input just after a falling edge and samples all outputs 2 ns later, still inside the same low phase. It then advances its reference stage model once, exactly as the next rising edge will. Each comparison therefore sees the state that exists between two edges. Because the stages have no reset, the bench first streams 130 enabled bits through the 128-stage line, then compares every output on every cycle.

// File: rtl/srl_pkg.sv
package srl_pkg;

   typedef enum logic [1:0] {
      CFG_4X32  = 2'b00,
      CFG_2X64  = 2'b01,
      CFG_1X128 = 2'b10,
      CFG_96P32 = 2'b11
   } srl_cfg_e;

   // index of the segment that heads the line containing segment k
   function automatic int unsigned head_of(srl_cfg_e c, int unsigned k);
      case (c)
         CFG_4X32:  return k;
         CFG_2X64:  return (k / 2) * 2;
         CFG_1X128: return 0;
         default:   return (k < 3) ? 0 : 3;
      endcase
   endfunction

   // number of segments in the line headed by segment k
   function automatic int unsigned span_of(srl_cfg_e c, int unsigned k);
      case (c)
         CFG_4X32:  return 1;
         CFG_2X64:  return 2;
         CFG_1X128: return 4;
         default:   return (k == 0) ? 3 : 1;
      endcase
   endfunction

   // mask for the segment-select address bits a line of sp segments uses
   function automatic int unsigned hi_mask(int unsigned sp);
      int unsigned m;
      m = 1;
      while (m < sp) m = m * 2;
      return m - 1;
   endfunction

endpackage

// File: rtl/srl_segment.sv
module srl_segment #(
   parameter  int DEPTH = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          shift_en_i,
   input  logic          ser_i,
   input  logic [AW-1:0] tap_addr_i,
   output logic          tap_o,
   output logic          tail_o
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("srl_segment: DEPTH must be a power of two of at least 2");
   end

   logic [DEPTH-1:0] stages;

   always_ff @(posedge clk_i) begin
      if (shift_en_i) stages <= {stages[DEPTH-2:0], ser_i};
   end

   assign tap_o  = stages[tap_addr_i];
   assign tail_o = stages[DEPTH-1];

   logic chk_live = 1'b0;
   always_ff @(posedge clk_i) chk_live <= 1'b1;

   a_r3_hold: assert property (@(posedge clk_i) disable iff (!chk_live)
      !shift_en_i |=> $stable(stages));

   a_r2_newest: assert property (@(posedge clk_i) disable iff (!chk_live)
      shift_en_i |=> (stages[0] == $past(ser_i)));

   a_r7_tail: assert property (@(posedge clk_i) disable iff (!chk_live)
      shift_en_i |=> (tail_o == $past(stages[DEPTH-2])));

endmodule

// File: rtl/srl_route.sv
module srl_route
   import srl_pkg::*;
#(
   parameter  int NSEG = 4,
   parameter  int LAW  = 5,
   parameter  int CAW  = 7,
   localparam int IW   = $clog2(NSEG)
) (
   input  logic [1:0]                cfg_i,
   input  logic [NSEG-1:0][CAW-1:0]  addr_i,
   output logic [NSEG-1:0]           link_o,
   output logic [NSEG-1:0][LAW-1:0]  seg_addr_o
);

   srl_cfg_e cfg;
   assign cfg = srl_cfg_e'(cfg_i);

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      assign link_o[k]     = (head_of(cfg, k) != k);
      assign seg_addr_o[k] = addr_i[IW'(head_of(cfg, k))][LAW-1:0];
   end

endmodule

// File: rtl/srl_out_sel.sv
module srl_out_sel
   import srl_pkg::*;
#(
   parameter  int NSEG = 4,
   parameter  int LAW  = 5,
   parameter  int CAW  = 7,
   localparam int IW   = $clog2(NSEG),
   localparam int HW   = CAW - LAW
) (
   input  logic [1:0]               cfg_i,
   input  logic [NSEG-1:0][CAW-1:0] addr_i,
   input  logic [NSEG-1:0]          seg_tap_i,
   output logic [NSEG-1:0]          tap_o
);

   srl_cfg_e cfg;
   assign cfg = srl_cfg_e'(cfg_i);

   for (genvar j = 0; j < NSEG; j++) begin : g_out
      always_comb begin
         int unsigned sp;
         int unsigned hm;
         logic [HW-1:0] hi;
         hi       = addr_i[j][CAW-1:LAW];
         sp       = span_of(cfg, j);
         hm       = 32'(hi) & hi_mask(sp);
         tap_o[j] = 1'b0;
         if (head_of(cfg, j) == j && hm < sp)
            tap_o[j] = seg_tap_i[IW'(j + hm)];
      end
   end

endmodule

// File: rtl/casc_srl_bank.sv
module casc_srl_bank
   import srl_pkg::*;
#(
   parameter  int SEG_DEPTH = 32,
   parameter  int NUM_SEG   = 4,
   localparam int LAW       = $clog2(SEG_DEPTH),
   localparam int CAW       = LAW + $clog2(NUM_SEG)
) (
   input  logic                        clk_i,
   input  logic                        shift_en_i,
   input  logic [1:0]                  cfg_i,
   input  logic [NUM_SEG-1:0]          ser_i,
   input  logic [NUM_SEG-1:0][CAW-1:0] addr_i,
   output logic [NUM_SEG-1:0]          tap_o,
   output logic [NUM_SEG-1:0]          tail_o
);

   if (NUM_SEG != 4) begin : g_bad_count
      $error("casc_srl_bank: the chaining configurations assume four segments");
   end

   logic [NUM_SEG-1:0]          link_w;
   logic [NUM_SEG-1:0][LAW-1:0] seg_addr_w;
   logic [NUM_SEG-1:0]          seg_in_w;
   logic [NUM_SEG-1:0]          seg_tap_w;

   logic chk_live = 1'b0;
   always_ff @(posedge clk_i) chk_live <= 1'b1;

   srl_route #(.NSEG(NUM_SEG), .LAW(LAW), .CAW(CAW)) u_route (
      .cfg_i      (cfg_i),
      .addr_i     (addr_i),
      .link_o     (link_w),
      .seg_addr_o (seg_addr_w)
   );

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      if (k == 0) begin : g_head
         assign seg_in_w[k] = ser_i[k];
      end else begin : g_body
         assign seg_in_w[k] = link_w[k] ? tail_w_prev : ser_i[k];
         logic tail_w_prev;
         assign tail_w_prev = tail_o[k-1];
      end

      srl_segment #(.DEPTH(SEG_DEPTH)) u_seg (
         .clk_i      (clk_i),
         .shift_en_i (shift_en_i),
         .ser_i      (seg_in_w[k]),
         .tap_addr_i (seg_addr_w[k]),
         .tap_o      (seg_tap_w[k]),
         .tail_o     (tail_o[k])
      );

      if (k > 0) begin : g_chk
         // R4, R5, R6: a joined segment takes the deepest bit of its neighbour
         a_r4_cascade: assert property (@(posedge clk_i) disable iff (!chk_live)
            (shift_en_i && link_w[k]) |=> (u_seg.stages[0] == $past(tail_o[k-1])));
         // R1: an unjoined segment takes its own serial input
         a_r1_own_input: assert property (@(posedge clk_i) disable iff (!chk_live)
            (shift_en_i && !link_w[k]) |=> (u_seg.stages[0] == $past(ser_i[k])));
      end
   end

   srl_out_sel #(.NSEG(NUM_SEG), .LAW(LAW), .CAW(CAW)) u_out (
      .cfg_i     (cfg_i),
      .addr_i    (addr_i),
      .seg_tap_i (seg_tap_w),
      .tap_o     (tap_o)
   );

   a_r5_quiet: assert property (@(posedge clk_i) disable iff (!chk_live)
      (cfg_i == CFG_1X128) |-> (tap_o[NUM_SEG-1:1] == '0));

   a_r4_quiet: assert property (@(posedge clk_i) disable iff (!chk_live)
      (cfg_i == CFG_2X64) |-> (tap_o[1] == 1'b0 && tap_o[3] == 1'b0));

   a_r6_quiet: assert property (@(posedge clk_i) disable iff (!chk_live)
      (cfg_i == CFG_96P32) |-> (tap_o[1] == 1'b0 && tap_o[2] == 1'b0));

   a_r6_range: assert property (@(posedge clk_i) disable iff (!chk_live)
      (cfg_i == CFG_96P32 && addr_i[0][CAW-1:LAW] == 2'b11) |-> (tap_o[0] == 1'b0));

endmodule

// File: tb/casc_srl_bank_tb_top.sv
`timescale 1ns/1ps
module casc_srl_bank_tb_top;

   logic            clk = 1'b0;
   logic            en;
   logic [1:0]      md;
   logic [3:0]      din;
   logic [3:0][6:0] ad;
   logic [3:0]      tap;
   logic [3:0]      tail;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] m [4];

   always #10 clk = ~clk;

   casc_srl_bank dut_i (
      .clk_i      (clk),
      .shift_en_i (en),
      .cfg_i      (md),
      .ser_i      (din),
      .addr_i     (ad),
      .tap_o      (tap),
      .tail_o     (tail)
   );

   function automatic logic linked(logic [1:0] c, int k);
      case (c)
         2'b00:   return 1'b0;
         2'b01:   return (k == 1 || k == 3);
         2'b10:   return (k > 0);
         default: return (k == 1 || k == 2);
      endcase
   endfunction

   function automatic logic exp_tap(int j);
      logic [6:0] a;
      a = ad[j];
      case (md)
         2'b00: return m[j][a[4:0]];
         2'b01: return (j % 2 == 0) ? m[j + int'(a[5])][a[4:0]] : 1'b0;
         2'b10: return (j == 0) ? m[a[6:5]][a[4:0]] : 1'b0;
         default: begin
            if (j == 0) return (a < 7'd96) ? m[a[6:5]][a[4:0]] : 1'b0;
            if (j == 3) return m[3][a[4:0]];
            return 1'b0;
         end
      endcase
   endfunction

   task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (cfg %b addr %h)", tag, got, exp, md, ad);
      end
   endtask

   task automatic step(logic e, logic [1:0] c, logic [3:0] d, logic [3:0][6:0] a, string tag);
      logic [3:0]  exp;
      logic [31:0] old [4];
      string t;
      @(negedge clk);
      en = e; md = c; din = d; ad = a;
      #2;
      for (int j = 0; j < 4; j++) exp[j] = exp_tap(j);
      if (tag != "") t = tag;
      else case (c)
         2'b00:   t = "R1";
         2'b01:   t = "R4";
         2'b10:   t = "R5";
         default: t = "R6";
      endcase
      check(t, tap, exp);
      check("R7", tail, {m[3][31], m[2][31], m[1][31], m[0][31]});
      if (e) begin
         for (int k = 0; k < 4; k++) old[k] = m[k];
         for (int k = 0; k < 4; k++)
            m[k] = {old[k][30:0], (k > 0 && linked(c, k)) ? old[k-1][31] : d[k]};
      end
   endtask

   function automatic logic [3:0][6:0] rnd_addr();
      logic [3:0][6:0] r;
      for (int k = 0; k < 4; k++) r[k] = 7'($urandom);
      return r;
   endfunction

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [3:0][6:0] a;
      void'($urandom(32'h5eed_0123));
      en = 1'b0; md = 2'b10; din = '0; ad = '0;
      for (int k = 0; k < 4; k++) m[k] = 'x;
      // stream data through the full 128-stage line; no compare until filled
      for (int i = 0; i < 130; i++) begin
         @(negedge clk);
         en = 1'b1; md = 2'b10; din = 4'($urandom); ad = '0;
         for (int k = 3; k > 0; k--) m[k] = {m[k][30:0], m[k-1][31]};
         m[0] = {m[0][30:0], din[0]};
      end
      // R2: newest bit at address 0
      step(1'b1, 2'b00, 4'b1010, '0, "R2");
      step(1'b0, 2'b00, 4'b0000, '0, "R2");
      check("R2", tap, 4'b1010);
      step(1'b1, 2'b00, 4'b0101, '0, "R2");
      step(1'b0, 2'b00, 4'b1111, '0, "R2");
      check("R2", tap, 4'b0101);
      // R3: hold while disabled, inputs toggling
      a = rnd_addr();
      for (int i = 0; i < 20; i++) step(1'b0, 2'(i % 4), 4'($urandom), a, "R3");
      // R8: address and configuration sweep with no shifting
      for (int i = 0; i < 128; i++) begin
         for (int k = 0; k < 4; k++) a[k] = 7'(i + 37 * k);
         step(1'b0, 2'(i / 32), 4'($urandom), a, "R8");
      end
      // R6: boundary addresses of the 96-stage line
      a = rnd_addr(); a[0] = 7'd95;  step(1'b0, 2'b11, 4'hF, a, "R6");
      a[0] = 7'd96;  step(1'b0, 2'b11, 4'hF, a, "R6");
      a[0] = 7'd127; step(1'b0, 2'b11, 4'hF, a, "R6");
      a[0] = 7'd0;   step(1'b1, 2'b11, 4'hF, a, "R6");
      // R9: upper address bits set on short lines
      for (int i = 0; i < 40; i++) begin
         a = rnd_addr();
         a[0][6] = 1'b1; a[2][6] = 1'b1;
         step(1'($urandom), 2'(i % 2), 4'($urandom), a, "R9");
      end
      // random mix of all configurations
      for (int i = 0; i < 3000; i++)
         step(($urandom % 4) != 0, 2'($urandom), 4'($urandom), rnd_addr(), "");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule